// File: doc/BRIEF.md
# Sub-Audio Tone Period Detector

This block decides whether one selected sub-audio squelch tone is present on a receive channel. It takes a one-bit sliced version of the sub-audio signal, counts timing ticks between successive rising edges of that signal, and compares each measured period with the period expected for the tone picked by a 6-bit tone code. Each comparison produces one hit or miss event. A raw flag follows the latest event.

The events feed a saturating up/down integrator. This integrator does the job of an external RC integrator and hysteresis comparator. Its level is compared against thresholds at one third and two thirds of full scale, which gives a debounced, active-low decode output. A receive-audio gate is derived from the decode output, a press-to-listen input and a "no tone" code.

The integrator moves one step per input cycle, so the time to decode grows as the tone frequency falls. A transmit-mode input puts the whole detector into its idle state.

Top module: `tonedet`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `decode_n_o` is 1 and `tone_flag_o` and `audio_gate_o` are 0.
- R2: Codes 0 to 38 select the 39 standard sub-audio tones in ascending frequency (code 0 = 67.0 Hz, code 37 = 241.8 Hz, code 38 = 250.3 Hz). The expected period E is round(1 000 000 / f) ticks, for example 3995 for code 38 and 4136 for code 37. Ticks are the cycles with `tick_en_i` = 1. A rising edge whose distance in ticks from the previous edge is P is a hit when |P − E| <= E/50 (integer division), and is a miss otherwise. `tone_flag_o` shows 1 after a hit and 0 after a miss.
- R3: The integrator level starts at 0. It rises by one per hit and falls by one per miss, and it saturates at 0 and at INT_MAX.
- R4: While `decode_n_o` is 1, it goes to 0 when the level reaches HI = (2*INT_MAX)/3.
- R5: While `decode_n_o` is 0, it stays 0 until the level falls to LO = INT_MAX/3, and then it returns to 1.
- R6: If TIMEOUT_TICKS ticks pass with no rising edge, that counts as one miss, and the next edge is not evaluated.
- R7: The first rising edge after reset or after any clear only starts a measurement. It produces no event.
- R8: A change of `code_i` clears the integrator to 0, sets `decode_n_o` to 1 and clears `tone_flag_o` on the next cycle.
- R9: With `rx_mode_i` = 0 (transmit), `decode_n_o` is 1, `tone_flag_o` is 0 and `audio_gate_o` is 0 whatever the input signal or `ptl_i`, and the integrator is held at 0.
- R10: With `rx_mode_i` = 1, `audio_gate_o` is 1 when `decode_n_o` is 0, or `ptl_i` is 1, or the code is a no-tone code. The gate lags its inputs by one cycle.
- R11: Codes 39 to 63 mean "no tone". In receive mode they keep `decode_n_o` at 1 and `tone_flag_o` at 0 even with a tone present, and they open the audio gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Timing tick enable (1 µs reference) |
| tone_in_i | input | 1 | Sliced sub-audio signal, asynchronous |
| rx_mode_i | input | 1 | 1 = receive, 0 = transmit |
| ptl_i | input | 1 | Press-to-listen: opens the audio gate in receive |
| code_i | input | CODE_W | Tone code (0..38 tones, 39 and above no tone) |
| tone_flag_o | output | 1 | Raw tone-detect flag, 1 after a hit |
| decode_n_o | output | 1 | Debounced decode, 0 = tone decoded |
| audio_gate_o | output | 1 | Receive-audio gate, 1 = open |

## Verification
The hardest state to reach from the ports is the middle of the hysteresis band on the way down. Here the level is between LO and HI with the decode still held, and it falls only because edges stop, not because a wrong period arrives. The bench first drives the level into saturation with extra hits. It then sends two short wrong-period edges and holds the input still across two timeout windows, checking the decode after one timeout and again after two. Both the clamp at full scale and the timeout path decide when the decode releases, so a fault in either one shows up there. Window edges are probed with gaps of exactly E ± E/50 and one tick beyond each.

// File: rtl/tonedet_pkg.sv
package tonedet_pkg;

  localparam int NUM_TONES      = 39;
  localparam int PER_W          = 16;
  localparam int LONGEST_PERIOD = 14925;

  // Period of each tone in 1 us ticks, round(1e6 / f), ascending frequency.
  function automatic logic [PER_W-1:0] tone_period(input int idx);
    case (idx)
      0:  tone_period = 16'd14925; // 67.0
      1:  tone_period = 16'd14430; // 69.3
      2:  tone_period = 16'd13908; // 71.9
      3:  tone_period = 16'd13441; // 74.4
      4:  tone_period = 16'd12987; // 77.0
      5:  tone_period = 16'd12547; // 79.7
      6:  tone_period = 16'd12121; // 82.5
      7:  tone_period = 16'd11710; // 85.4
      8:  tone_period = 16'd11299; // 88.5
      9:  tone_period = 16'd10929; // 91.5
      10: tone_period = 16'd10549; // 94.8
      11: tone_period = 16'd10267; // 97.4
      12: tone_period = 16'd10000; // 100.0
      13: tone_period = 16'd9662;  // 103.5
      14: tone_period = 16'd9328;  // 107.2
      15: tone_period = 16'd9017;  // 110.9
      16: tone_period = 16'd8711;  // 114.8
      17: tone_period = 16'd8418;  // 118.8
      18: tone_period = 16'd8130;  // 123.0
      19: tone_period = 16'd7855;  // 127.3
      20: tone_period = 16'd7587;  // 131.8
      21: tone_period = 16'd7326;  // 136.5
      22: tone_period = 16'd7077;  // 141.3
      23: tone_period = 16'd6840;  // 146.2
      24: tone_period = 16'd6605;  // 151.4
      25: tone_period = 16'd6382;  // 156.7
      26: tone_period = 16'd6165;  // 162.2
      27: tone_period = 16'd5956;  // 167.9
      28: tone_period = 16'd5754;  // 173.8
      29: tone_period = 16'd5559;  // 179.9
      30: tone_period = 16'd5371;  // 186.2
      31: tone_period = 16'd5187;  // 192.8
      32: tone_period = 16'd4914;  // 203.5
      33: tone_period = 16'd4746;  // 210.7
      34: tone_period = 16'd4585;  // 218.1
      35: tone_period = 16'd4431;  // 225.7
      36: tone_period = 16'd4281;  // 233.6
      37: tone_period = 16'd4136;  // 241.8
      38: tone_period = 16'd3995;  // 250.3
      default: tone_period = '0;
    endcase
  endfunction

endpackage

// File: rtl/tonedet_edge.sv
// Synchronises the sliced tone input and flags rising edges on tick cycles.
module tonedet_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en_i,
  input  logic din_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      if (tick_en_i) prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = tick_en_i & sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tonedet_meter.sv
// Counts ticks between rising edges and classifies each period against a window.
module tonedet_meter #(
  parameter int PER_W         = 16,
  parameter int TIMEOUT_TICKS = 29850
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic             tick_en_i,
  input  logic             rise_i,
  input  logic [PER_W-1:0] win_lo_i,
  input  logic [PER_W-1:0] win_hi_i,
  output logic             evt_v_o,
  output logic             evt_hit_o
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             in_win;
  logic             expired;

  assign in_win  = (int'(cnt_q) >= int'(win_lo_i)) && (int'(cnt_q) <= int'(win_hi_i));
  assign expired = int'(cnt_q) >= TIMEOUT_TICKS;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      cnt_q     <= CNT_W'(1);
      armed_q   <= 1'b0;
      evt_v_o   <= 1'b0;
      evt_hit_o <= 1'b0;
    end else begin
      evt_v_o <= 1'b0;
      if (tick_en_i) begin
        if (rise_i) begin
          cnt_q   <= CNT_W'(1);
          armed_q <= 1'b1;
          if (armed_q) begin
            evt_v_o   <= 1'b1;
            evt_hit_o <= in_win;
          end
        end else if (expired) begin
          cnt_q     <= CNT_W'(1);
          armed_q   <= 1'b0;
          evt_v_o   <= 1'b1;
          evt_hit_o <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/tonedet_integ.sv
// Saturating up/down integrator with a two-threshold (hysteresis) decision.
module tonedet_integ #(
  parameter int INT_MAX = 24,
  parameter int LVL_W   = $clog2(INT_MAX + 1)
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic             evt_v_i,
  input  logic             evt_hit_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             dec_n_o
);

  localparam int HI = (2 * INT_MAX) / 3;
  localparam int LO = INT_MAX / 3;

  logic [LVL_W-1:0] nxt;

  always_comb begin
    nxt = lvl_o;
    if (evt_hit_i) begin
      if (int'(lvl_o) < INT_MAX) nxt = lvl_o + LVL_W'(1);
    end else begin
      if (lvl_o != '0) nxt = lvl_o - LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (clr_i) begin
      lvl_o   <= '0;
      dec_n_o <= 1'b1;
    end else if (evt_v_i) begin
      lvl_o <= nxt;
      if (dec_n_o) dec_n_o <= !(int'(nxt) >= HI);
      else         dec_n_o <= (int'(nxt) <= LO);
    end
  end

endmodule

// File: rtl/tonedet.sv
module tonedet
  import tonedet_pkg::*;
#(
  parameter int CODE_W        = 6,
  parameter int INT_MAX       = 24,
  parameter int TIMEOUT_TICKS = 2 * LONGEST_PERIOD,
  parameter int TOL_DIV       = 50,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en_i,
  input  logic              tone_in_i,
  input  logic              rx_mode_i,
  input  logic              ptl_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tone_flag_o,
  output logic              decode_n_o,
  output logic              audio_gate_o
);

  localparam int LVL_W = $clog2(INT_MAX + 1);

  logic [CODE_W-1:0] code_q;
  logic              notone;
  logic              code_chg;
  logic              clr;
  logic [PER_W-1:0]  exp_q;
  logic [PER_W-1:0]  win_lo_q;
  logic [PER_W-1:0]  win_hi_q;
  logic              rise;
  logic              evt_v;
  logic              evt_hit;
  logic [LVL_W-1:0]  lvl_w;

  assign notone   = int'(code_i) >= NUM_TONES;
  assign code_chg = code_i != code_q;
  assign clr      = rst | code_chg | ~rx_mode_i | notone;

  always_ff @(posedge clk) begin
    code_q <= code_i;
  end

  // Tone ROM and acceptance window, registered so the divide stays off the edge path.
  always_ff @(posedge clk) begin
    exp_q    <= tone_period(int'(code_i));
    win_lo_q <= PER_W'(int'(exp_q) - int'(exp_q) / TOL_DIV);
    win_hi_q <= PER_W'(int'(exp_q) + int'(exp_q) / TOL_DIV);
  end

  tonedet_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .tick_en_i (tick_en_i),
    .din_i     (tone_in_i),
    .rise_o    (rise)
  );

  tonedet_meter #(.PER_W(PER_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_meter (
    .clk       (clk),
    .clr_i     (clr),
    .tick_en_i (tick_en_i),
    .rise_i    (rise),
    .win_lo_i  (win_lo_q),
    .win_hi_i  (win_hi_q),
    .evt_v_o   (evt_v),
    .evt_hit_o (evt_hit)
  );

  tonedet_integ #(.INT_MAX(INT_MAX), .LVL_W(LVL_W)) u_integ (
    .clk       (clk),
    .clr_i     (clr),
    .evt_v_i   (evt_v),
    .evt_hit_i (evt_hit),
    .lvl_o     (lvl_w),
    .dec_n_o   (decode_n_o)
  );

  always_ff @(posedge clk) begin
    if (clr)        tone_flag_o <= 1'b0;
    else if (evt_v) tone_flag_o <= evt_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) audio_gate_o <= 1'b0;
    else     audio_gate_o <= rx_mode_i & (~decode_n_o | ptl_i | notone);
  end

endmodule

// File: rtl/tonedet_chk.sv
module tonedet_chk #(
  parameter int CODE_W  = 6,
  parameter int INT_MAX = 24,
  parameter int LVL_W   = $clog2(INT_MAX + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_mode_i,
  input logic              ptl_i,
  input logic [CODE_W-1:0] code_i,
  input logic              tone_flag_o,
  input logic              decode_n_o,
  input logic              audio_gate_o,
  input logic [LVL_W-1:0]  lvl
);

  localparam int HI = (2 * INT_MAX) / 3;
  localparam int LO = INT_MAX / 3;

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(lvl) <= INT_MAX); // R3
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (rst)
    $changed(lvl) |-> (int'(lvl) <= int'($past(lvl)) + 1)); // R3
  AST_DECODE_AT_HI: assert property (@(posedge clk) disable iff (rst)
    $fell(decode_n_o) |-> (int'(lvl) == HI)); // R4
  AST_RELEASE_AT_LO: assert property (@(posedge clk) disable iff (rst)
    $rose(decode_n_o) |-> (int'(lvl) <= LO)); // R5
  AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (code_i != $past(code_i)) |=> (decode_n_o && !tone_flag_o && lvl == '0)); // R8
  AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rx_mode_i |=> (decode_n_o && !tone_flag_o && !audio_gate_o)); // R9
  AST_PTL_OPENS: assert property (@(posedge clk) disable iff (rst)
    (rx_mode_i && ptl_i) |=> audio_gate_o); // R10
  AST_NOTONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rx_mode_i && int'(code_i) >= tonedet_pkg::NUM_TONES) |=>
      (decode_n_o && !tone_flag_o && audio_gate_o)); // R11

endmodule

bind tonedet tonedet_chk #(.CODE_W(CODE_W), .INT_MAX(INT_MAX), .LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_mode_i    (rx_mode_i),
  .ptl_i        (ptl_i),
  .code_i       (code_i),
  .tone_flag_o  (tone_flag_o),
  .decode_n_o   (decode_n_o),
  .audio_gate_o (audio_gate_o),
  .lvl          (lvl_w)
);

// File: tb/tb_tonedet.sv
`timescale 1ns/1ps
module tb_tonedet;

  localparam int INT_MAX  = 6;
  localparam int TIMEOUT  = 9000;
  localparam int HIGH_T   = 1000;
  localparam int E38      = int'(1000000.0 / 250.3);
  localparam int E37      = int'(1000000.0 / 241.8);
  localparam int W38      = E38 / 50;

  typedef struct packed {
    logic       rx;
    logic       ptl;
    logic [5:0] code;
    logic       gate;
  } vec_t;

  // Idle (no tone) gate expectations per R9, R10, R11.
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 6'd38, 1'b0},
    '{1'b1, 1'b1, 6'd38, 1'b1},
    '{1'b1, 1'b0, 6'd63, 1'b1},
    '{1'b1, 1'b0, 6'd45, 1'b1},
    '{1'b0, 1'b1, 6'd38, 1'b0},
    '{1'b0, 1'b0, 6'd63, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       tone_in = 1'b0;
  logic       rx_mode = 1'b1;
  logic       ptl = 1'b0;
  logic [5:0] code = 6'd38;
  logic       tone_flag, decode_n, audio_gate;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tonedet #(.CODE_W(6), .INT_MAX(INT_MAX), .TIMEOUT_TICKS(TIMEOUT)) dut (
    .clk          (clk),
    .rst          (rst),
    .tick_en_i    (tick_en),
    .tone_in_i    (tone_in),
    .rx_mode_i    (rx_mode),
    .ptl_i        (ptl),
    .code_i       (code),
    .tone_flag_o  (tone_flag),
    .decode_n_o   (decode_n),
    .audio_gate_o (audio_gate)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Rising edge exactly `gap` ticks after the previous one; returns HIGH_T after it.
  task automatic send_edge(input int gap);
    tone_in = 1'b0;
    repeat (gap - HIGH_T) @(negedge clk);
    tone_in = 1'b1;
    repeat (HIGH_T) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 decode_n after reset", decode_n, 1'b1);
    check("R1 flag after reset", tone_flag, 1'b0);
    check("R1 gate after reset", audio_gate, 1'b0);

    for (int i = 0; i < 6; i++) begin
      rx_mode = VECS[i].rx;
      ptl     = VECS[i].ptl;
      code    = VECS[i].code;
      repeat (4) @(negedge clk);
      check("R10/R11/R9 idle gate", audio_gate, VECS[i].gate);
      check("R9/R11 idle decode_n", decode_n, 1'b1);
      check("R9/R11 idle flag", tone_flag, 1'b0);
    end

    rx_mode = 1'b1; ptl = 1'b0; code = 6'd38;
    repeat (4) @(negedge clk);

    // R7: first edge only arms; R2 hits; R4 threshold at HI = 4.
    send_edge(E38);
    check("R7 first edge no event", tone_flag, 1'b0);
    send_edge(E38);
    check("R2 hit sets flag", tone_flag, 1'b1);
    send_edge(E38);
    send_edge(E38);
    check("R4 three hits below HI", decode_n, 1'b1);
    send_edge(E38);
    check("R4 decode at HI", decode_n, 1'b0);
    check("R10 gate opens on decode", audio_gate, 1'b1);

    // R8: code change clears.
    send_edge(E38);
    send_edge(E38);
    code = 6'd37;
    repeat (3) @(negedge clk);
    check("R8 decode_n after code change", decode_n, 1'b1);
    check("R8 flag after code change", tone_flag, 1'b0);
    check("R10 gate closes after clear", audio_gate, 1'b0);
    for (int i = 0; i < 4; i++) send_edge(E37);
    check("R8 integrator restarted from 0", decode_n, 1'b1);
    send_edge(E37);
    check("R4 decode on new code", decode_n, 1'b0);

    // R3 saturation, R5 hysteresis, R6 timeout.
    for (int i = 0; i < 3; i++) send_edge(E37);
    send_edge(3500);
    check("R2 miss clears flag", tone_flag, 1'b0);
    send_edge(3500);
    check("R5 held above LO", decode_n, 1'b0);
    repeat (11000) @(negedge clk);
    check("R6 one timeout, still held", decode_n, 1'b0);
    check("R6 flag after timeout", tone_flag, 1'b0);
    repeat (10000) @(negedge clk);
    check("R3/R5/R6 release at LO", decode_n, 1'b1);

    // R2 window boundaries.
    code = 6'd38;
    repeat (4) @(negedge clk);
    send_edge(4000);
    send_edge(E38 + W38);
    check("R2 upper edge hit", tone_flag, 1'b1);
    send_edge(E38 + W38 + 1);
    check("R2 beyond upper edge miss", tone_flag, 1'b0);
    send_edge(E38 - W38);
    check("R2 lower edge hit", tone_flag, 1'b1);
    send_edge(E38 - W38 - 1);
    check("R2 beyond lower edge miss", tone_flag, 1'b0);

    // R9 transmit ignores the tone and PTL.
    rx_mode = 1'b0; ptl = 1'b1;
    for (int i = 0; i < 3; i++) send_edge(E38);
    check("R9 tx flag", tone_flag, 1'b0);
    check("R9 tx decode_n", decode_n, 1'b1);
    check("R9 tx gate", audio_gate, 1'b0);

    // R11 no-tone code in receive with a tone present.
    rx_mode = 1'b1; ptl = 1'b0; code = 6'd63;
    for (int i = 0; i < 3; i++) send_edge(E38);
    check("R11 notone flag", tone_flag, 1'b0);
    check("R11 notone decode_n", decode_n, 1'b1);
    check("R11 notone gate", audio_gate, 1'b1);

    finish_run();
  end

endmodule